// File: doc/BRIEF.md
# Instruction Issue Interlock with Bubble Insertion

This block sits at the issue point of a short in-order load/store pipeline whose instruction and data memories are separate. Register-to-register operations need only fetch and execute, while loads and stores add a memory phase after the address step. A value returned by a load therefore reaches the register file later than an arithmetic result does. Every cycle the block compares the instruction offered by fetch with the loads issued in the last few slots. When an operand would be read too early, it sends a no-operation slot down the pipe in place of the instruction. After every branch it also fills the slots that the pipeline cannot use.

A parameter selects the pipeline shape. In the short shape the pipeline has fetch, execute and memory phases, and the hazard window is one slot. In the long shape the execute phase is split into a register-read step and an ALU/write-back step, which widens the window to two slots. The block still inserts only as many bubbles as the distance to the producing load requires. The inbound instruction stream uses valid/ready. An instruction is taken on a clock edge where `in_valid` and `in_ready` are both high. While `in_ready` is low, fetch must hold the instruction and its fields stable. The outbound side carries no back-pressure: the pipeline advances every cycle, and `out_valid` marks a slot that holds an instruction or a bubble. `stall` is the complement of `in_ready`. `nop_count` totals the bubbles issued since reset.

Top module: `ilk_issue_gate`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `out_valid` is 0, `stall` is 0 and `nop_count` is 0.
- R2: An instruction taken on an edge appears in the following cycle with `out_valid`=1 and `out_nop`=0, and with its class, destination and sources unchanged. Class codes are 0 register-to-register, 1 load, 2 store and 3 branch. A cycle in which nothing is taken and no bubble is due gives `out_valid`=0.
- R3: An instruction that reads the nonzero destination of the load issued in the immediately preceding slot is preceded by one bubble in the short shape and by two bubbles in the long shape.
- R4: When one slot separates the load from its consumer, the short shape inserts no bubble and the long shape inserts one.
- R5: A branch is always followed by as many bubbles as the hazard window is long (1 or 2), whatever instruction comes next.
- R6: A load whose destination is register 0 never causes a bubble.
- R7: `stall` is high in exactly the cycles in which a bubble is being issued. During those cycles `in_ready` is low and the offered instruction is held, not dropped.
- R8: `nop_count` increases by one for every bubble issued.
- R9: Idle cycles with no instruction offered count toward the distance from a load, in the same way as issued slots.
- R10: Loads and branches read only source 1, so a match on their source 2 field causes no bubble. Stores and register-to-register operations read both sources.
- R11: The destinations of register-to-register operations never cause a bubble, because their results are available to the next instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Fetch offers an instruction |
| in_ready | output | 1 | Offered instruction is taken on this edge |
| in_cls | input | 2 | Instruction class code |
| in_dst | input | REG_AW | Destination register |
| in_src1 | input | REG_AW | First source register |
| in_src2 | input | REG_AW | Second source register |
| out_valid | output | 1 | Issue slot holds an instruction or a bubble |
| out_nop | output | 1 | Issue slot is a bubble |
| out_cls | output | 2 | Issued class (0 for a bubble) |
| out_dst | output | REG_AW | Issued destination (0 for a bubble) |
| out_src1 | output | REG_AW | Issued first source (0 for a bubble) |
| out_src2 | output | REG_AW | Issued second source (0 for a bubble) |
| stall | output | 1 | Fetch is held while a bubble is issued |
| nop_count | output | CNT_W | Bubbles issued since reset |

## Verification
Both pipeline shapes run side by side on one bench. Each shape sees a load followed by its consumer at distance one, at distance two through an unrelated instruction, and at distance two through an idle cycle. A design that ignored the distance would over-stall the long shape. A design that dropped idle cycles from the count would stall when no stall is due. Further cases are a load to register 0, a source 2 match on a load or branch, and a store whose data register was just loaded. A design that matched register 0 or the unused field would insert bubbles where none belong. A design that skipped the second source of a store would forward a stale value. The bench also covers a branch whose own operand comes from a load, where the load-use bubbles and the branch-shadow bubbles must stack in order. The stall cycle counts are compared with the bubbles seen at the output, so a design that let an instruction slip past during a bubble is caught.

// File: rtl/ilk_pkg.sv
package ilk_pkg;

  typedef enum logic [1:0] {
    CLS_ALU    = 2'd0,
    CLS_LOAD   = 2'd1,
    CLS_STORE  = 2'd2,
    CLS_BRANCH = 2'd3
  } ins_cls_e;

  // Which classes read the second source operand.
  function automatic logic cls_reads_src2(ins_cls_e c);
    return (c == CLS_ALU) || (c == CLS_STORE);
  endfunction

endpackage

// File: rtl/ilk_load_window.sv
// Remembers which recent issue slots carried a load with a live destination
// and reports how many bubbles the candidate still needs.
module ilk_load_window #(
  parameter int DEPTH = 1,
  parameter int RAW   = 5,
  parameter int NW    = 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           push_load,
  input  logic [RAW-1:0] push_dst,
  input  logic [RAW-1:0] chk_src1,
  input  logic [RAW-1:0] chk_src2,
  input  logic           chk_use2,
  output logic [NW-1:0]  need
);

  logic [DEPTH-1:0] h_vld;
  logic [RAW-1:0]   h_dst [DEPTH];
  logic [DEPTH-1:0] hit;

  // Entry k describes the slot issued k+1 cycles ago.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_vld <= '0;
      for (int k = 0; k < DEPTH; k++) h_dst[k] <= '0;
    end else begin
      h_vld[0] <= push_load;
      h_dst[0] <= push_dst;
      for (int k = 1; k < DEPTH; k++) begin
        h_vld[k] <= h_vld[k-1];
        h_dst[k] <= h_dst[k-1];
      end
    end
  end

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_match
      assign hit[g] = h_vld[g] &&
                      ((h_dst[g] == chk_src1) ||
                       (chk_use2 && (h_dst[g] == chk_src2)));
    end
  endgenerate

  // The youngest matching load sets the bubble count.
  always_comb begin
    need = '0;
    for (int k = DEPTH - 1; k >= 0; k--) begin
      if (hit[k]) need = NW'(DEPTH - k);
    end
  end

endmodule

// File: rtl/ilk_branch_shadow.sv
// Counts down the bubble slots that follow a taken branch.
module ilk_branch_shadow #(
  parameter int DEPTH = 1,
  parameter int NW    = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);

  logic [NW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left <= '0;
    end else if (start) begin
      left <= NW'(DEPTH);
    end else if (left != '0) begin
      left <= left - 1'b1;
    end
  end

  assign busy = (left != '0);

endmodule

// File: rtl/ilk_event_counter.sv
module ilk_event_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] count
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count <= '0;
    else if (inc) count <= count + 1'b1;
  end

endmodule

// File: rtl/ilk_issue_gate.sv
module ilk_issue_gate #(
  parameter int REG_AW     = 5,
  parameter bit FOUR_PHASE = 1'b0,
  parameter int CNT_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        in_cls,
  input  logic [REG_AW-1:0] in_dst,
  input  logic [REG_AW-1:0] in_src1,
  input  logic [REG_AW-1:0] in_src2,
  output logic              out_valid,
  output logic              out_nop,
  output logic [1:0]        out_cls,
  output logic [REG_AW-1:0] out_dst,
  output logic [REG_AW-1:0] out_src1,
  output logic [REG_AW-1:0] out_src2,
  output logic              stall,
  output logic [CNT_W-1:0]  nop_count
);
  import ilk_pkg::*;

  localparam int SLOTS = FOUR_PHASE ? 2 : 1;
  localparam int NW    = $clog2(SLOTS + 1);

  ins_cls_e      cls_in;
  logic          use2;
  logic [NW-1:0] ld_need;
  logic          br_busy;
  logic          hold;
  logic          take;
  logic          load_push;
  logic          br_start;

  assign cls_in = ins_cls_e'(in_cls);
  assign use2   = cls_reads_src2(cls_in);

  ilk_load_window #(
    .DEPTH (SLOTS),
    .RAW   (REG_AW),
    .NW    (NW)
  ) u_window (
    .clk      (clk),
    .rst_n    (rst_n),
    .push_load(load_push),
    .push_dst (in_dst),
    .chk_src1 (in_src1),
    .chk_src2 (in_src2),
    .chk_use2 (use2),
    .need     (ld_need)
  );

  ilk_branch_shadow #(
    .DEPTH (SLOTS),
    .NW    (NW)
  ) u_shadow (
    .clk  (clk),
    .rst_n(rst_n),
    .start(br_start),
    .busy (br_busy)
  );

  // A bubble goes out when the branch shadow is open or the offered
  // instruction would read a load result that is not yet written.
  assign hold      = br_busy | (in_valid & (ld_need != '0));
  assign take      = in_valid & ~hold;
  assign load_push = take & (cls_in == CLS_LOAD) & (in_dst != '0);
  assign br_start  = take & (cls_in == CLS_BRANCH);
  assign in_ready  = ~hold;
  assign stall     = hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_nop   <= 1'b0;
      out_cls   <= '0;
      out_dst   <= '0;
      out_src1  <= '0;
      out_src2  <= '0;
    end else begin
      out_valid <= hold | take;
      out_nop   <= hold;
      out_cls   <= take ? in_cls  : '0;
      out_dst   <= take ? in_dst  : '0;
      out_src1  <= take ? in_src1 : '0;
      out_src2  <= take ? in_src2 : '0;
    end
  end

  ilk_event_counter #(
    .W (CNT_W)
  ) u_nops (
    .clk  (clk),
    .rst_n(rst_n),
    .inc  (hold),
    .count(nop_count)
  );

endmodule

// File: rtl/ilk_issue_gate_chk.sv
module ilk_issue_gate_chk #(
  parameter int REG_AW = 5,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [1:0]        in_cls,
  input logic [REG_AW-1:0] in_dst,
  input logic [REG_AW-1:0] in_src1,
  input logic              stall,
  input logic              out_valid,
  input logic              out_nop,
  input logic [CNT_W-1:0]  nop_count
);

  assert_hold_gives_bubble_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (out_valid && out_nop));

  assert_take_gives_instr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !stall) |=> (out_valid && !out_nop));

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !stall) |=> !out_valid);

  assert_branch_shadow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !stall && in_cls == 2'd3) |=> stall);

  assert_load_use_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && $past(in_valid && !stall && in_cls == 2'd1 && in_dst != '0)
     && in_src1 == $past(in_dst)) |-> stall);

  assert_bubble_counted_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_nop) |-> (nop_count == CNT_W'($past(nop_count) + 1'b1)));

endmodule

bind ilk_issue_gate ilk_issue_gate_chk #(
  .REG_AW (REG_AW),
  .CNT_W  (CNT_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_cls   (in_cls),
  .in_dst   (in_dst),
  .in_src1  (in_src1),
  .stall    (stall),
  .out_valid(out_valid),
  .out_nop  (out_nop),
  .nop_count(nop_count)
);

// File: tb/ilk_issue_gate_tb.sv
module ilk_issue_gate_tb;

  localparam int PERIOD = 10;
  localparam logic [1:0] C_ALU = 2'd0, C_LD = 2'd1, C_ST = 2'd2, C_BR = 2'd3;

  typedef struct {
    logic       nop;
    logic [1:0] cls;
    logic [4:0] dst;
    logic [4:0] s1;
    logic [4:0] s2;
    string      tag;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  logic        vi  [2];
  logic [1:0]  ci  [2];
  logic [4:0]  di  [2];
  logic [4:0]  ai  [2];
  logic [4:0]  bi  [2];
  logic        rdy [2];
  logic        ov  [2];
  logic        on  [2];
  logic [1:0]  oc  [2];
  logic [4:0]  od  [2];
  logic [4:0]  o1  [2];
  logic [4:0]  o2  [2];
  logic        st  [2];
  logic [15:0] nc  [2];

  ilk_issue_gate #(.REG_AW(5), .FOUR_PHASE(1'b0), .CNT_W(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(vi[0]), .in_ready(rdy[0]),
    .in_cls(ci[0]), .in_dst(di[0]), .in_src1(ai[0]), .in_src2(bi[0]),
    .out_valid(ov[0]), .out_nop(on[0]), .out_cls(oc[0]), .out_dst(od[0]),
    .out_src1(o1[0]), .out_src2(o2[0]), .stall(st[0]), .nop_count(nc[0]));

  ilk_issue_gate #(.REG_AW(5), .FOUR_PHASE(1'b1), .CNT_W(16)) u_dut4 (
    .clk(clk), .rst_n(rst_n), .in_valid(vi[1]), .in_ready(rdy[1]),
    .in_cls(ci[1]), .in_dst(di[1]), .in_src1(ai[1]), .in_src2(bi[1]),
    .out_valid(ov[1]), .out_nop(on[1]), .out_cls(oc[1]), .out_dst(od[1]),
    .out_src1(o1[1]), .out_src2(o2[1]), .stall(st[1]), .nop_count(nc[1]));

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  item_t q0[$];
  item_t q1[$];
  int br_end [2];
  int lslot  [2][4];
  int ldst   [2][4];
  bit lvld   [2][4];
  int lptr   [2];
  int nops   [2];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic push(input int m, input item_t it);
    if (m == 0) q0.push_back(it);
    else        q1.push_back(it);
  endtask

  task automatic push_nop(input int m, input string tag);
    item_t it;
    it.nop = 1'b1; it.cls = '0; it.dst = '0; it.s1 = '0; it.s2 = '0; it.tag = tag;
    push(m, it);
    nops[m]++;
  endtask

  // Monitor: every occupied issue slot must match the queue head.
  always @(negedge clk) begin
    if (rst_n) begin
      for (int m = 0; m < 2; m++) begin
        if (ov[m]) begin
          item_t e;
          int    sz;
          sz = (m == 0) ? q0.size() : q1.size();
          if (sz == 0) begin
            chk(1'b0, "R2", $sformatf("unexpected slot mode %0d", m), 1, 0);
          end else begin
            e = (m == 0) ? q0.pop_front() : q1.pop_front();
            chk(on[m] == e.nop, e.tag, $sformatf("bubble flag mode %0d", m),
                int'(on[m]), int'(e.nop));
            chk({oc[m], od[m], o1[m], o2[m]} == {e.cls, e.dst, e.s1, e.s2}, e.tag,
                $sformatf("issued fields mode %0d", m),
                int'({oc[m], od[m], o1[m], o2[m]}), int'({e.cls, e.dst, e.s1, e.s2}));
          end
        end
      end
    end
  end

  // Driver: offers one instruction, predicts its bubbles from the rules.
  task automatic send(input int m, input logic [1:0] c, input logic [4:0] d,
                      input logic [4:0] a, input logic [4:0] b, input string tag);
    int    win;
    int    now;
    int    start;
    int    earliest;
    int    stalls;
    bit    use2;
    item_t it;
    win  = m + 1;
    use2 = (c == C_ALU) || (c == C_ST);
    @(negedge clk);
    now   = cyc;
    start = (br_end[m] > now) ? br_end[m] : now;
    earliest = start;
    for (int i = 0; i < 4; i++) begin
      if (lvld[m][i] && ((ldst[m][i] == int'(a)) || (use2 && ldst[m][i] == int'(b))))
        if (lslot[m][i] + win + 1 > earliest) earliest = lslot[m][i] + win + 1;
    end
    for (int i = 0; i < earliest - start; i++) push_nop(m, tag);
    it.nop = 1'b0; it.cls = c; it.dst = d; it.s1 = a; it.s2 = b; it.tag = tag;
    push(m, it);
    if (c == C_LD && d != 5'd0) begin
      lslot[m][lptr[m]] = earliest;
      ldst[m][lptr[m]]  = int'(d);
      lvld[m][lptr[m]]  = 1'b1;
      lptr[m] = (lptr[m] + 1) % 4;
    end
    if (c == C_BR) begin
      br_end[m] = earliest + win + 1;
      for (int i = 0; i < win; i++) push_nop(m, "R5");
    end
    vi[m] = 1'b1; ci[m] = c; di[m] = d; ai[m] = a; bi[m] = b;
    stalls = 0;
    #1;
    while (st[m]) begin
      chk(rdy[m] == 1'b0, "R7", "ready during stall", int'(rdy[m]), 0);
      stalls++;
      @(negedge clk);
      #1;
    end
    chk(stalls == earliest - now, tag, $sformatf("stall cycles mode %0d", m),
        stalls, earliest - now);
    @(posedge clk);
    #1;
    vi[m] = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_mode(input int m);
    send(m, C_ALU, 5'd1, 5'd2, 5'd3, "R2");
    // immediate load-use
    send(m, C_LD,  5'd3, 5'd1, 5'd0, "R2");
    send(m, C_ALU, 5'd4, 5'd3, 5'd5, "R3");
    // one unrelated slot in between
    send(m, C_LD,  5'd6, 5'd1, 5'd0, "R2");
    send(m, C_ALU, 5'd7, 5'd1, 5'd2, "R4");
    send(m, C_ALU, 5'd8, 5'd6, 5'd1, "R4");
    // register 0 destination
    send(m, C_LD,  5'd0, 5'd2, 5'd0, "R6");
    send(m, C_ALU, 5'd1, 5'd0, 5'd0, "R6");
    // branch shadow, then branch fed by a load
    send(m, C_BR,  5'd0, 5'd2, 5'd0, "R5");
    send(m, C_ALU, 5'd2, 5'd4, 5'd5, "R5");
    send(m, C_LD,  5'd9, 5'd1, 5'd0, "R3");
    send(m, C_BR,  5'd0, 5'd9, 5'd0, "R3");
    send(m, C_ALU, 5'd3, 5'd9, 5'd9, "R5");
    // idle cycle counts toward distance
    send(m, C_LD,  5'd10, 5'd1, 5'd0, "R9");
    idle(1);
    send(m, C_ALU, 5'd11, 5'd10, 5'd2, "R9");
    // unused second source on load and branch
    send(m, C_LD,  5'd12, 5'd1, 5'd0, "R10");
    send(m, C_LD,  5'd13, 5'd2, 5'd12, "R10");
    send(m, C_LD,  5'd14, 5'd3, 5'd0, "R10");
    send(m, C_BR,  5'd0, 5'd5, 5'd14, "R10");
    // store data operand uses the second source
    send(m, C_LD,  5'd15, 5'd1, 5'd0, "R10");
    send(m, C_ST,  5'd0, 5'd2, 5'd15, "R10");
    // arithmetic results never stall
    send(m, C_ALU, 5'd16, 5'd1, 5'd2, "R11");
    send(m, C_ALU, 5'd17, 5'd16, 5'd16, "R11");
    send(m, C_ST,  5'd0, 5'd17, 5'd16, "R11");
    // load-use through the second source of an arithmetic op
    send(m, C_LD,  5'd18, 5'd1, 5'd0, "R3");
    send(m, C_ALU, 5'd19, 5'd2, 5'd18, "R3");
    idle(4);
  endtask

  initial begin
    #(PERIOD * 200000);
    fails++;
    $display("FAIL R7 watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int m = 0; m < 2; m++) begin
      vi[m] = 1'b0; ci[m] = '0; di[m] = '0; ai[m] = '0; bi[m] = '0;
      br_end[m] = 0; lptr[m] = 0; nops[m] = 0;
      for (int i = 0; i < 4; i++) begin
        lvld[m][i] = 1'b0; lslot[m][i] = 0; ldst[m][i] = 0;
      end
    end
    repeat (3) @(negedge clk);
    for (int m = 0; m < 2; m++) begin
      chk(ov[m] == 1'b0, "R1", "out_valid in reset", int'(ov[m]), 0);
      chk(nc[m] == 16'd0, "R1", "nop_count in reset", int'(nc[m]), 0);
    end
    rst_n = 1'b1;
    @(negedge clk);
    for (int m = 0; m < 2; m++) begin
      chk(ov[m] == 1'b0, "R1", "out_valid after reset", int'(ov[m]), 0);
      chk(st[m] == 1'b0, "R1", "stall after reset", int'(st[m]), 0);
      chk(nc[m] == 16'd0, "R1", "nop_count after reset", int'(nc[m]), 0);
    end
    run_mode(0);
    run_mode(1);
    idle(4);
    chk(q0.size() == 0, "R2", "pending slots short shape", q0.size(), 0);
    chk(q1.size() == 0, "R2", "pending slots long shape", q1.size(), 0);
    for (int m = 0; m < 2; m++)
      chk(int'(nc[m]) == nops[m], "R8", $sformatf("bubble total mode %0d", m),
          int'(nc[m]), nops[m]);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule